// File: doc/BRIEF.md
# Frame Clock Lock Monitor

This block decides whether an incoming frame clock is still locked to the system clock. It runs a free-running counter on the system clock and reads that counter at every rising frame-clock edge. The counter value taken when lock is acquired becomes the reference phase. Any fixed offset between the two clocks is accepted, because only changes against that reference count.

Each later edge is compared with the reference. The difference is folded into a signed range, and its magnitude is converted to bit-clock periods. A large shift declares the link unlocked. While the link is unlocked, the stereo sample path is muted to the bipolar-zero code. A short acquisition sequence then captures a new reference and confirms it before the samples pass again. A one-cycle strobe marks each return to lock.

When the converter generates its own frame clock (master mode), loss of lock cannot occur. The monitor is then held idle and the samples pass through unchanged.

Top module: `frame_lock_monitor`

## Requirements
- R1: While reset is asserted and right after it, `sync_lost_o` is 1, `resync_o` is 0, and both sample outputs are zero.
- R2: Acquisition runs in three steps. The first frame edge seen while unlocked captures the counter as the new reference, at any phase. If the next two edges both measure a drift below 5 bit periods, the block locks. `sync_lost_o` falls after the second of those edges.
- R3: Drift is the counter value at an edge minus the reference, taken modulo the frame length in system cycles. Values of half a frame or more count as negative. Its size in bit periods is the floor of the magnitude divided by the system-cycles-per-bit ratio (4 by default). While locked, a size above 6 in either direction raises `sync_lost_o` within the same frame.
- R4: While locked, an edge whose drift is below 5 bit periods leaves the block locked. Each sample output then equals its input delayed by one clock.
- R5: A drift of exactly 5 or 6 bit periods changes nothing. A locked block stays locked. An acquiring block neither counts that frame as good nor restarts.
- R6: Whenever `sync_lost_o` is 1, both sample outputs on the next cycle are the bipolar-zero code 24'h000000.
- R7: `resync_o` is high for exactly one cycle on each transition into lock. In that cycle `sync_lost_o` is already 0, and in the cycle before it `sync_lost_o` was 1.
- R8: While `master_mode_i` is 1, `sync_lost_o` and `resync_o` stay 0 and samples pass with one cycle of delay, whatever the frame clock does. On return to slave mode, the block starts acquisition from the beginning, muted.
- R9: During acquisition, after the reference has been captured, an edge with drift above 6 bit periods re-captures the reference at that edge and restarts the good-frame count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_clk_i | input | 1 | Frame clock; its rising edge marks a sample period |
| master_mode_i | input | 1 | 1 = frame clock generated locally, monitor bypassed |
| left_i | input | 24 | Left sample in |
| right_i | input | 24 | Right sample in |
| left_o | output | 24 | Left sample out, muted while unlocked |
| right_o | output | 24 | Right sample out, muted while unlocked |
| sync_lost_o | output | 1 | 1 while the frame clock is not locked (slave mode only) |
| resync_o | output | 1 | One-cycle pulse when lock is regained |

## Verification
The bench moves the frame edge by chosen amounts relative to the captured reference, in both directions. It probes drift of 4, 5, 6 and 7 bit periods on each side.

- A design that used a strict inequality on the wrong side, or rounded instead of truncating, would unlock at 6 periods or stay locked at 7.
- A design with broken hysteresis would count a 5-period frame as good during acquisition, so its strobe would arrive a frame early.
- A design that kept the old reference after a large jump during acquisition would lock at the wrong frame, or not at all.
- A design that let mode changes leak through would raise the flag or strobe in master mode, or resume unmuted after switching back to slave mode.

Random drift sequences, checked against a frame-level model, catch mistakes in the modular wrap of the drift.

// File: rtl/frame_lock_pkg.sv
package frame_lock_pkg;

  // Tracking state of the lock machine
  typedef enum logic [1:0] {
    ST_ACQUIRE = 2'd0,
    ST_VERIFY  = 2'd1,
    ST_LOCKED  = 2'd2
  } lock_state_e;

  // Verdict on one frame edge, from its drift against the reference
  typedef enum logic [1:0] {
    DRIFT_GOOD = 2'd0,
    DRIFT_HOLD = 2'd1,
    DRIFT_LOSS = 2'd2
  } drift_class_e;

endpackage

// File: rtl/frame_edge_sync.sv
module frame_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_clk_i,
  output logic rise_o
);

  // Synchronizer chain plus one history flop for edge detection
  logic [SYNC_STAGES:0] shift_q;
  logic [SYNC_STAGES:0] shift_d;

  always_comb begin
    shift_d = {shift_q[SYNC_STAGES-1:0], frame_clk_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else begin
      shift_q <= shift_d;
    end
  end

  assign rise_o = shift_q[SYNC_STAGES-1] & ~shift_q[SYNC_STAGES];

endmodule

// File: rtl/frame_drift_meter.sv
module frame_drift_meter
  import frame_lock_pkg::*;
#(
  parameter int FRAME_CYC = 256,  // system cycles per frame
  parameter int BIT_CYC   = 4,    // system cycles per bit clock, power of two
  parameter int LOSS_BITS = 6,    // drift above this is a loss
  parameter int GOOD_BITS = 5,    // drift below this is good
  localparam int CW       = $clog2(FRAME_CYC)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [CW-1:0] ref_phase_i,
  output logic [CW-1:0] phase_o,
  output drift_class_e class_o
);

  localparam int BIT_SH = $clog2(BIT_CYC);
  localparam int HALF   = FRAME_CYC / 2;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW:0]   diff, mag, drift_bits;

  // Free-running phase counter, wraps once per nominal frame
  always_comb begin
    if (cnt_q == CW'(FRAME_CYC - 1)) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // Modular difference folded into a signed magnitude, then bit units
  always_comb begin
    if (cnt_q >= ref_phase_i) begin
      diff = {1'b0, cnt_q} - {1'b0, ref_phase_i};
    end else begin
      diff = {1'b0, cnt_q} + (CW+1)'(FRAME_CYC) - {1'b0, ref_phase_i};
    end
    if (diff >= (CW+1)'(HALF)) begin
      mag = (CW+1)'(FRAME_CYC) - diff;
    end else begin
      mag = diff;
    end
    drift_bits = mag >> BIT_SH;
    if (drift_bits > (CW+1)'(LOSS_BITS)) begin
      class_o = DRIFT_LOSS;
    end else if (drift_bits < (CW+1)'(GOOD_BITS)) begin
      class_o = DRIFT_GOOD;
    end else begin
      class_o = DRIFT_HOLD;
    end
  end

  assign phase_o = cnt_q;

endmodule

// File: rtl/frame_lock_fsm.sv
module frame_lock_fsm
  import frame_lock_pkg::*;
#(
  parameter int CW          = 8,
  parameter int LOCK_FRAMES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master_i,
  input  logic          rise_i,
  input  logic [CW-1:0] phase_i,
  input  drift_class_e  class_i,
  output logic [CW-1:0] ref_o,
  output logic          muted_o,
  output logic          resync_o
);

  localparam int GW = $clog2(LOCK_FRAMES + 1);

  lock_state_e   state_q, state_d;
  logic [CW-1:0] ref_q;
  logic          ref_en;
  logic [GW-1:0] good_q, good_d;
  logic          resync_q, resync_d;

  always_comb begin
    state_d  = state_q;
    good_d   = good_q;
    ref_en   = 1'b0;
    resync_d = 1'b0;
    if (master_i) begin
      state_d = ST_ACQUIRE;
      good_d  = '0;
    end else if (rise_i) begin
      unique case (state_q)
        ST_ACQUIRE: begin
          ref_en  = 1'b1;
          good_d  = '0;
          state_d = ST_VERIFY;
        end
        ST_VERIFY: begin
          if (class_i == DRIFT_LOSS) begin
            ref_en = 1'b1;
            good_d = '0;
          end else if (class_i == DRIFT_GOOD) begin
            if (good_q == GW'(LOCK_FRAMES - 1)) begin
              state_d  = ST_LOCKED;
              good_d   = '0;
              resync_d = 1'b1;
            end else begin
              good_d = good_q + GW'(1);
            end
          end
        end
        ST_LOCKED: begin
          if (class_i == DRIFT_LOSS) begin
            state_d = ST_ACQUIRE;
            good_d  = '0;
          end
        end
        default: begin
          state_d = ST_ACQUIRE;
          good_d  = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_ACQUIRE;
      good_q   <= '0;
      resync_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      good_q   <= good_d;
      resync_q <= resync_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
    end else if (ref_en) begin
      ref_q <= phase_i;
    end
  end

  assign ref_o    = ref_q;
  assign muted_o  = (state_q != ST_LOCKED);
  assign resync_o = resync_q;

endmodule

// File: rtl/sample_mute_gate.sv
module sample_mute_gate #(
  parameter int NCH = 2,
  parameter int DW  = 24
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mute_i,
  input  logic [NCH-1:0][DW-1:0] data_i,
  output logic [NCH-1:0][DW-1:0] data_o
);

  // Bipolar zero in two's complement is all zeros
  localparam logic [DW-1:0] BPZ = '0;

  logic [NCH-1:0][DW-1:0] data_d, data_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign data_d[c] = mute_i ? BPZ : data_i[c];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q[c] <= BPZ;
      end else begin
        data_q[c] <= data_d[c];
      end
    end
  end

  assign data_o = data_q;

endmodule

// File: rtl/frame_lock_monitor.sv
module frame_lock_monitor
  import frame_lock_pkg::*;
#(
  parameter int SYS_PER_BIT   = 4,
  parameter int SYS_PER_FRAME = 256,
  parameter int SAMPLE_W      = 24,
  parameter int LOSS_BITS     = 6,
  parameter int GOOD_BITS     = 5,
  parameter int LOCK_FRAMES   = 2,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_clk_i,
  input  logic                master_mode_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                sync_lost_o,
  output logic                resync_o
);

  localparam int CW  = $clog2(SYS_PER_FRAME);
  localparam int NCH = 2;

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_core_n = rst_sync_q[1];

  logic          rise;
  logic [CW-1:0] phase, ref_phase;
  drift_class_e  verdict;
  logic          muted;

  frame_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .frame_clk_i (frame_clk_i),
    .rise_o      (rise)
  );

  frame_drift_meter #(
    .FRAME_CYC (SYS_PER_FRAME),
    .BIT_CYC   (SYS_PER_BIT),
    .LOSS_BITS (LOSS_BITS),
    .GOOD_BITS (GOOD_BITS)
  ) u_meter (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .ref_phase_i (ref_phase),
    .phase_o     (phase),
    .class_o     (verdict)
  );

  frame_lock_fsm #(
    .CW          (CW),
    .LOCK_FRAMES (LOCK_FRAMES)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .master_i (master_mode_i),
    .rise_i   (rise),
    .phase_i  (phase),
    .class_i  (verdict),
    .ref_o    (ref_phase),
    .muted_o  (muted),
    .resync_o (resync_o)
  );

  assign sync_lost_o = muted & ~master_mode_i;

  logic [NCH-1:0][SAMPLE_W-1:0] gate_in, gate_out;

  assign gate_in = {right_i, left_i};

  sample_mute_gate #(.NCH(NCH), .DW(SAMPLE_W)) u_gate (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .mute_i (sync_lost_o),
    .data_i (gate_in),
    .data_o (gate_out)
  );

  assign left_o  = gate_out[0];
  assign right_o = gate_out[1];

endmodule

// File: rtl/frame_lock_monitor_chk.sv
module frame_lock_monitor_chk #(
  parameter int SAMPLE_W = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic                master_mode_i,
  input logic [SAMPLE_W-1:0] left_i,
  input logic [SAMPLE_W-1:0] right_i,
  input logic [SAMPLE_W-1:0] left_o,
  input logic [SAMPLE_W-1:0] right_o,
  input logic                sync_lost_o,
  input logic                resync_o
);

  // R8: master mode never reports loss
  p_master_no_loss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    master_mode_i |-> !sync_lost_o);

  // R6: flagged loss mutes both channels on the following cycle
  p_mute_bpz_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_lost_o |=> (left_o == '0 && right_o == '0));

  // R4: locked slave path forwards samples with one cycle delay
  p_pass_through_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_lost_o && !master_mode_i) |=>
      (left_o == $past(left_i) && right_o == $past(right_i)));

  // R7: strobe lasts one cycle
  p_resync_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    resync_o |=> !resync_o);

  // R7: strobe coincides with loss clearing
  p_resync_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    resync_o |-> (!sync_lost_o && $past(sync_lost_o)));

endmodule

bind frame_lock_monitor frame_lock_monitor_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .master_mode_i (master_mode_i),
  .left_i        (left_i),
  .right_i       (right_i),
  .left_o        (left_o),
  .right_o       (right_o),
  .sync_lost_o   (sync_lost_o),
  .resync_o      (resync_o)
);

// File: tb/frame_lock_monitor_tb.sv
`timescale 1ns/1ps
module frame_lock_monitor_tb;

  localparam int FR = 256;
  localparam int BC = 4;
  localparam int W  = 24;

  logic         clk = 1'b0;
  logic         rst_n, frame_clk, master;
  logic [W-1:0] l_in, r_in, l_out, r_out;
  logic         lost, resync;

  always #2.5 clk = ~clk;

  frame_lock_monitor u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_clk_i   (frame_clk),
    .master_mode_i (master),
    .left_i        (l_in),
    .right_i       (r_in),
    .left_o        (l_out),
    .right_o       (r_out),
    .sync_lost_o   (lost),
    .resync_o      (resync)
  );

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Frame-level model: 0 acquire, 1 verify, 2 locked
  int    m_state = 0;
  int    m_ref   = 0;
  int    m_good  = 0;
  int    m_lock  = 0;
  string m_tag   = "R2";

  function automatic int drift_bits(int pos, int refp);
    int d;
    d = ((pos - refp) % FR + FR) % FR;
    if (d >= FR / 2) d = FR - d;
    return d / BC;
  endfunction

  function automatic void model_edge(int pos, bit mst);
    int b;
    m_lock = 0;
    if (mst) begin
      m_state = 0; m_good = 0; m_tag = "R8";
      return;
    end
    b = drift_bits(pos, m_ref);
    case (m_state)
      0: begin m_ref = pos; m_good = 0; m_state = 1; m_tag = "R2"; end
      1: begin
        if (b > 6) begin m_ref = pos; m_good = 0; m_tag = "R9"; end
        else if (b < 5) begin
          m_tag = "R2";
          if (m_good == 1) begin m_state = 2; m_good = 0; m_lock = 1; end
          else m_good++;
        end else m_tag = "R5";
      end
      default: begin
        if (b > 6) begin m_state = 0; m_good = 0; m_tag = "R3"; end
        else if (b < 5) m_tag = "R4";
        else m_tag = "R5";
      end
    endcase
  endfunction

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_frame(int shift, bit mst);
    int  pulses;
    bit  exp_lost;
    string dtag;
    master    = mst;
    frame_clk = 1'b1;
    l_in      = W'($urandom);
    r_in      = W'($urandom);
    model_edge(cyc, mst);
    pulses = 0;
    for (int i = 0; i < FR + shift; i++) begin
      @(negedge clk);
      if (i == FR / 2 - 1) frame_clk = 1'b0;
      if (resync) pulses++;
      if (i == 24) begin
        exp_lost = !mst && (m_state != 2);
        dtag = exp_lost ? "R6" : m_tag;
        check(m_tag, "sync_lost", lost, exp_lost);
        check(dtag, "left_o", l_out, exp_lost ? 0 : l_in);
        check(dtag, "right_o", r_out, exp_lost ? 0 : r_in);
      end
    end
    check(mst ? "R8" : "R7", "resync pulses", pulses, m_lock);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    rst_n = 1'b0; frame_clk = 1'b0; master = 1'b0; l_in = '1; r_in = '1;
    repeat (5) @(negedge clk);
    check("R1", "sync_lost in reset", lost, 1);
    check("R1", "left_o in reset", l_out, 0);
    check("R1", "resync in reset", resync, 0);
    rst_n = 1'b1;
    repeat (37) @(negedge clk);
    check("R1", "sync_lost after reset", lost, 1);
    check("R1", "right_o after reset", r_out, 0);

    // R2: acquisition at arbitrary phase
    run_frame(0, 0); run_frame(0, 0); run_frame(0, 0);
    // R4 / R5 / R3: positive drift boundaries while locked
    run_frame(19, 0); run_frame(-19, 0);
    run_frame(20, 0); run_frame(7, 0); run_frame(1, 0);
    // R5 during acquisition: 5-period frame must not count
    run_frame(0, 0); run_frame(22, 0); run_frame(-22, 0); run_frame(0, 0);
    // R5 / R3: negative boundaries
    run_frame(-27, 0); run_frame(-1, 0);
    // R9: recapture during acquisition
    run_frame(0, 0); run_frame(40, 0); run_frame(0, 0); run_frame(0, 0);
    // R8: master mode with large jumps, then back to slave
    run_frame(50, 1); run_frame(-40, 1); run_frame(0, 1);
    run_frame(0, 0); run_frame(0, 0); run_frame(0, 0);
    // Random drift sequences
    for (int k = 0; k < 30; k++) begin
      int s;
      s = int'($urandom_range(0, 40)) - 20;
      if ($urandom_range(0, 5) == 0) s = int'($urandom_range(0, 70)) - 35;
      run_frame(s, 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule